// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block decides which message mailbox a CAN transmit engine sends next. It holds a bank of mailboxes. Each mailbox has an enable bit, a direction bit, a pending-request bit, an acknowledge bit, an interrupt mask bit and a programmable transmit priority. A mailbox is a candidate when it is enabled, set for transmit and has a request pending. Among the candidates, the one with the numerically largest priority wins. When priorities are equal, the higher mailbox index wins.

Software works through a single write port. The address selects one of these targets:
- the enable vector
- the direction vector
- the request-set vector, where a written 1 sets a bit
- the acknowledge-clear vector, where a written 1 clears a bit
- the interrupt mask
- one mailbox's control word

The engine sees a registered winner. It accepts that winner with `tx_start` and then reports either `tx_done` (success) or `tx_fail` (retry later). While a frame is in flight the choice is held fixed. A success raises the acknowledge bit of that mailbox, and a masked-in acknowledge raises an interrupt.

Top module: `can_txmb_arbiter`

## Requirements
- R1: After reset the request, acknowledge, enable, direction and mask vectors are zero, every priority is zero, `sel_valid`, `busy` and `irq` are 0.
- R2: A mailbox takes part only when its enable bit is 1 (address 0), its direction bit is 0 (address 1, 1 means receive) and its request bit is 1.
- R3: Address 5 writes the control word of mailbox `wr_mbx`, and its priority sits in bits 13:8. Among the candidates, the largest priority is selected.
- R4: Between candidates of equal priority, the higher mailbox index is selected.
- R5: While idle, `sel_valid`/`sel_idx`/`sel_prio` show the winner of the state seen at the previous clock edge. `tx_start` with `sel_valid` high sets `busy`, and from then until `tx_done` or `tx_fail` the selection does not change. `tx_start` while `sel_valid` is low is ignored.
- R6: `tx_done` while busy sets the acknowledge bit of the in-flight mailbox and clears its request. It also ends `busy` and drops `sel_valid` for one cycle before re-arbitration. If `tx_done` and `tx_fail` come together, `tx_done` wins.
- R7: `tx_fail` while busy ends `busy`, leaves the request pending and sets no acknowledge bit.
- R8: A write to address 2 sets each request bit written as 1, and a write to address 3 clears each acknowledge bit written as 1. Bits written as 0 are left unchanged.
- R9: `irq_flags` is the bitwise AND of the acknowledge and mask (address 4) vectors, and `irq` is high when any flag is set.
- R10: A write to address 0 that turns off a mailbox with a pending request that is not in flight clears that request and sets no acknowledge bit.
- R11: When a transmit success falls in the same cycle as a software write to the same mailbox, the success's acknowledge-set beats an acknowledge-clear. A request-set beats the success's request-clear.
- R12: With no candidate, `sel_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write target: 0 enable, 1 direction, 2 request set, 3 ack clear, 4 mask, 5 control word |
| wr_mbx | input | IDX_W (5) | Mailbox index for control-word writes |
| wr_data | input | NMBX (32) | Write data |
| tx_start | input | 1 | Engine accepts the current selection |
| tx_done | input | 1 | In-flight frame sent successfully |
| tx_fail | input | 1 | In-flight frame not sent, to be retried |
| sel_valid | output | 1 | A selection is offered |
| sel_idx | output | IDX_W (5) | Selected mailbox index |
| sel_prio | output | PRIO_W (6) | Priority of the selected mailbox |
| busy | output | 1 | A frame is in flight |
| req_bits | output | NMBX (32) | Pending request vector |
| ack_bits | output | NMBX (32) | Acknowledge vector |
| irq_flags | output | NMBX (32) | Per-mailbox interrupt flags |
| irq | output | 1 | Any interrupt flag set |

## Verification
Two functions can land on the same mailbox in one cycle: the engine's success report, and a software write that touches the request or acknowledge bit of that mailbox. The bench drives `tx_done` in the same cycle as an acknowledge-clear write for the in-flight mailbox. It then repeats this with a request-set write. After that edge it expects the acknowledge bit still set in the first case and the request still pending in the second. A third overlap is a disable write during flight. The bench checks that it does not drop the in-flight request before the engine reports.

// File: rtl/can_txmb_arbiter.sv
module can_txmb_arbiter #(
  parameter int NMBX     = 32,
  parameter int PRIO_W   = 6,
  parameter int PRIO_LSB = 8,
  localparam int IDX_W   = $clog2(NMBX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [IDX_W-1:0]  wr_mbx,
  input  logic [NMBX-1:0]   wr_data,
  input  logic              tx_start,
  input  logic              tx_done,
  input  logic              tx_fail,
  output logic              sel_valid,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [PRIO_W-1:0] sel_prio,
  output logic              busy,
  output logic [NMBX-1:0]   req_bits,
  output logic [NMBX-1:0]   ack_bits,
  output logic [NMBX-1:0]   irq_flags,
  output logic              irq
);
  localparam logic [2:0] A_EN = 3'd0, A_DIR = 3'd1, A_RSET = 3'd2,
                         A_ACLR = 3'd3, A_MASK = 3'd4, A_CTRL = 3'd5;

  logic [NMBX-1:0]   en_q, dir_q, req_q, ack_q, mask_q;
  logic [PRIO_W-1:0] prio_q [NMBX];
  logic              busy_q;

  wire we_en   = wr_en && wr_addr == A_EN;
  wire we_dir  = wr_en && wr_addr == A_DIR;
  wire we_rset = wr_en && wr_addr == A_RSET;
  wire we_aclr = wr_en && wr_addr == A_ACLR;
  wire we_mask = wr_en && wr_addr == A_MASK;
  wire we_ctrl = wr_en && wr_addr == A_CTRL;

  wire [NMBX-1:0] onehot_sel = NMBX'(1) << sel_idx;
  wire [NMBX-1:0] inflight   = busy_q ? onehot_sel : '0;
  wire            ok_evt     = busy_q && tx_done;
  wire            end_evt    = busy_q && (tx_done || tx_fail);
  wire [NMBX-1:0] done_mask  = ok_evt ? onehot_sel : '0;
  wire [NMBX-1:0] set_mask   = we_rset ? wr_data : '0;
  wire [NMBX-1:0] clr_mask   = we_aclr ? wr_data : '0;
  wire [NMBX-1:0] drop_mask  = we_en ? (en_q & ~wr_data & ~inflight) : '0;
  wire [NMBX-1:0] cand       = en_q & ~dir_q & req_q;

  logic              win_vld;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;

  always_comb begin
    win_vld  = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NMBX; i++) begin
      if (cand[i] && (!win_vld || prio_q[i] >= win_prio)) begin
        win_vld  = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      dir_q  <= '0;
      req_q  <= '0;
      ack_q  <= '0;
      mask_q <= '0;
    end else begin
      if (we_en)   en_q   <= wr_data;
      if (we_dir)  dir_q  <= wr_data;
      if (we_mask) mask_q <= wr_data;
      req_q <= (req_q & ~done_mask & ~drop_mask) | set_mask;
      ack_q <= (ack_q & ~clr_mask) | done_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NMBX; i++) prio_q[i] <= '0;
    end else if (we_ctrl) begin
      prio_q[wr_mbx] <= wr_data[PRIO_LSB +: PRIO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      sel_valid <= 1'b0;
      sel_idx   <= '0;
      sel_prio  <= '0;
    end else if (busy_q) begin
      if (end_evt) begin
        busy_q    <= 1'b0;
        sel_valid <= 1'b0;
      end
    end else if (tx_start && sel_valid) begin
      busy_q <= 1'b1;
    end else begin
      sel_valid <= win_vld;
      sel_idx   <= win_idx;
      sel_prio  <= win_prio;
    end
  end

  assign busy      = busy_q;
  assign req_bits  = req_q;
  assign ack_bits  = ack_q;
  assign irq_flags = ack_q & mask_q;
  assign irq       = |irq_flags;
endmodule

// File: rtl/can_txmb_arbiter_chk.sv
module can_txmb_arbiter_chk #(
  parameter int NMBX  = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_q,
  input logic             sel_valid,
  input logic [IDX_W-1:0] sel_idx,
  input logic             tx_start,
  input logic             tx_done,
  input logic             tx_fail,
  input logic [NMBX-1:0]  en_q,
  input logic [NMBX-1:0]  dir_q,
  input logic [NMBX-1:0]  req_q,
  input logic [NMBX-1:0]  ack_q,
  input logic             irq
);
  wire [NMBX-1:0] cand_w = en_q & ~dir_q & req_q;

  AST_SEL_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !$past(busy_q) && !$past(tx_start && sel_valid))
      |-> ((($past(cand_w) >> sel_idx) & NMBX'(1)) != '0)); // R2

  AST_FROZEN_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(sel_idx)); // R5

  AST_START_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(tx_start && sel_valid)); // R5

  AST_DONE_SETS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tx_done) |=> (((ack_q >> $past(sel_idx)) & NMBX'(1)) != '0) && !busy_q); // R6

  AST_FAIL_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tx_fail && !tx_done) |=> (((req_q >> $past(sel_idx)) & NMBX'(1)) != '0)); // R7

  AST_IRQ_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ack_q != '0)); // R9
endmodule

bind can_txmb_arbiter can_txmb_arbiter_chk #(.NMBX(NMBX), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_q(busy_q), .sel_valid(sel_valid),
  .sel_idx(sel_idx), .tx_start(tx_start), .tx_done(tx_done), .tx_fail(tx_fail),
  .en_q(en_q), .dir_q(dir_q), .req_q(req_q), .ack_q(ack_q), .irq(irq)
);

// File: tb/can_txmb_arbiter_bench.sv
`timescale 1ns/1ps
module can_txmb_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [4:0]  wr_mbx = '0;
  logic [31:0] wr_data = '0;
  logic        tx_start = 1'b0, tx_done = 1'b0, tx_fail = 1'b0;
  logic        sel_valid, busy, irq;
  logic [4:0]  sel_idx;
  logic [5:0]  sel_prio;
  logic [31:0] req_bits, ack_bits, irq_flags;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  can_txmb_arbiter u_can_txmb_arbiter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_mbx(wr_mbx),
    .wr_data(wr_data), .tx_start(tx_start), .tx_done(tx_done), .tx_fail(tx_fail),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_prio(sel_prio), .busy(busy),
    .req_bits(req_bits), .ack_bits(ack_bits), .irq_flags(irq_flags), .irq(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input int m, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_mbx = 5'(m); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prio(input int m, input int p);
    wr(3'd5, m, 32'(p) << 8);
  endtask

  task automatic pulse_start();
    tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
  endtask

  task automatic setup_tx_all();
    wr(3'd0, 0, 32'hFFFF_FFFF);
    wr(3'd1, 0, 32'h0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 req", req_bits, 0);
    chk("R1 ack", ack_bits, 0);
    chk("R1 valid", {30'd0, sel_valid, busy}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_qualify();
    do_reset();
    wr(3'd0, 0, ~(32'h1 << 9));
    wr(3'd1, 0, 32'h1 << 7);
    prio(7, 63); prio(3, 10); prio(9, 62);
    wr(3'd2, 0, (32'h1 << 7) | (32'h1 << 3) | (32'h1 << 9));
    tick(1);
    chk("R2 rx and disabled skipped", {26'd0, sel_valid, sel_idx}, {26'd0, 1'b1, 5'd3});
    wr(3'd1, 0, 32'h0);
    tick(1);
    chk("R2 turned to tx", {26'd0, sel_valid, sel_idx}, {26'd0, 1'b1, 5'd7});
  endtask

  task automatic t_prio();
    do_reset(); setup_tx_all();
    prio(5, 20); prio(20, 5); prio(12, 40);
    wr(3'd2, 0, (32'h1 << 5) | (32'h1 << 20) | (32'h1 << 12));
    tick(1);
    chk("R3 index", {27'd0, sel_idx}, 12);
    chk("R3 prio", {26'd0, sel_prio}, 40);
  endtask

  task automatic t_tie_freeze_done();
    do_reset(); setup_tx_all();
    prio(2, 7); prio(4, 7); prio(17, 7); prio(30, 7);
    wr(3'd2, 0, (32'h1 << 2) | (32'h1 << 4) | (32'h1 << 17) | (32'h1 << 30));
    tick(1);
    chk("R4 tie higher index", {27'd0, sel_idx}, 30);
    pulse_start();
    chk("R5 busy after start", {31'd0, busy}, 1);
    prio(31, 63);
    wr(3'd2, 0, 32'h1 << 31);
    wr(3'd0, 0, ~(32'h1 << 30));
    tick(2);
    chk("R5 frozen", {27'd0, sel_idx}, 30);
    chk("R10 in-flight kept", req_bits[30], 1);
    pulse_done();
    chk("R6 ack", ack_bits, 32'h1 << 30);
    chk("R6 req cleared", req_bits[30], 0);
    chk("R6 idle gap", {30'd0, busy, sel_valid}, 0);
    tick(1);
    chk("R5 rearbitrate", {26'd0, sel_valid, sel_idx}, {26'd0, 1'b1, 5'd31});
  endtask

  task automatic t_fail();
    do_reset(); setup_tx_all();
    prio(6, 3);
    wr(3'd2, 0, 32'h1 << 6);
    tick(1);
    pulse_start();
    tx_fail = 1'b1; @(negedge clk); tx_fail = 1'b0;
    chk("R7 req kept", req_bits, 32'h1 << 6);
    chk("R7 no ack", ack_bits, 0);
    chk("R7 busy off", {31'd0, busy}, 0);
    tick(1);
    chk("R7 offered again", {26'd0, sel_valid, sel_idx}, {26'd0, 1'b1, 5'd6});
  endtask

  task automatic t_w1s_w1c_irq();
    do_reset(); setup_tx_all();
    wr(3'd2, 0, 32'h11);
    wr(3'd2, 0, 32'h100);
    chk("R8 set zeros no effect", req_bits, 32'h111);
    tick(1);
    pulse_start(); pulse_done(); tick(1);
    pulse_start(); pulse_done();
    chk("R8 two acks", ack_bits, 32'h110);
    wr(3'd3, 0, 32'h100);
    chk("R8 w1c", ack_bits, 32'h010);
    wr(3'd3, 0, 32'h0);
    chk("R8 clear zeros no effect", ack_bits, 32'h010);
    wr(3'd4, 0, 32'h010);
    chk("R9 flags", irq_flags, 32'h010);
    chk("R9 irq", {31'd0, irq}, 1);
    wr(3'd4, 0, 32'h100);
    chk("R9 masked off", {31'd0, irq}, 0);
  endtask

  task automatic t_drop();
    do_reset(); setup_tx_all();
    wr(3'd2, 0, (32'h1 << 8) | (32'h1 << 3));
    tick(1);
    chk("R4 tie at zero prio", {27'd0, sel_idx}, 8);
    wr(3'd0, 0, ~(32'h1 << 8));
    chk("R10 dropped", req_bits, 32'h1 << 3);
    tick(1);
    chk("R10 next winner", {26'd0, sel_valid, sel_idx}, {26'd0, 1'b1, 5'd3});
    wr(3'd0, 0, 32'h0);
    tick(1);
    chk("R12 none valid", {31'd0, sel_valid}, 0);
    chk("R10 no ack", ack_bits, 0);
  endtask

  task automatic t_collide();
    do_reset(); setup_tx_all();
    wr(3'd2, 0, 32'h1 << 10);
    tick(1);
    pulse_start(); pulse_done();
    wr(3'd2, 0, 32'h1 << 10);
    tick(1);
    pulse_start();
    tx_done = 1'b1; wr(3'd3, 0, 32'h1 << 10); tx_done = 1'b0;
    chk("R11 set beats clear ack", ack_bits, 32'h1 << 10);
    wr(3'd2, 0, 32'h1 << 10);
    tick(1);
    pulse_start();
    tx_done = 1'b1; wr(3'd2, 0, 32'h1 << 10); tx_done = 1'b0;
    chk("R11 set beats clear req", req_bits, 32'h1 << 10);
  endtask

  task automatic t_none();
    do_reset(); setup_tx_all();
    tick(1);
    chk("R12 empty", {31'd0, sel_valid}, 0);
    pulse_start();
    chk("R5 start ignored", {31'd0, busy}, 0);
    wr(3'd2, 0, 32'h2);
    tick(1);
    chk("R12 then offered", {26'd0, sel_valid, sel_idx}, {26'd0, 1'b1, 5'd1});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_qualify();
    t_prio();
    t_tie_freeze_done();
    t_fail();
    t_w1s_w1c_irq();
    t_drop();
    t_collide();
    t_none();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end
endmodule